// File: doc/BRIEF.md
# Indirect Local Register Bus Bridge

This block lets a host reach a 32-bit internal register bus through four small registers in configuration space. The host first loads an address and, for a store, a data word. It then writes a control register, which launches exactly one access on the local bus. The bridge holds a request until the local side acknowledges, optionally with an error flag. It then posts the outcome in a two-bit result field of a status register. On a successful load, the returned word replaces the contents of the data register.

While an access is outstanding, the result field reads zero and further configuration writes are dropped. A host that keeps seeing zero treats the access as lost. An internal watchdog guarantees that a silent local bus still ends the access, with an error result. Software clears the result by writing zero to the status register before it issues the next command.

Top module: `lbus_cfg_bridge`

## Requirements
- R1: After reset, the address, data, control and status registers all read zero, and `lb_req` is low.
- R2: The register select codes are 0 for address, 1 for data, 2 for control and 3 for status. A write to address or data while idle is returned by a read of the same select. Read data appears on `cfg_rd_data` after the first rising edge at which `cfg_rd_sel` is sampled.
- R3: A control write with bit 0 set starts a local store. In the cycle after the write, `lb_req` and `lb_we` are high, with `lb_addr` equal to the address register and `lb_wdata` equal to the data register.
- R4: A control write with bit 0 clear starts a local load (`lb_we` low). If the acknowledge carries no error, the data register takes `lb_rdata`.
- R5: `lb_req` stays high until the edge that samples `lb_ack` high (or the watchdog expires), and is low from the following cycle.
- R6: The status result field (bits 1:0) is 01 for done, 10 for error, and 00 while an access is in flight. Launching a command clears any previous result to 00.
- R7: An acknowledge with `lb_err` high sets the result to 10. On a load, the data register keeps its previous value.
- R8: If no acknowledge arrives within TIMEOUT cycles of the launching edge, the access is aborted: `lb_req` falls and the result becomes 10.
- R9: While an access is in flight, writes to the address, data, control and status registers are ignored, and no new command starts.
- R10: An idle write of zero to the status register clears the result to 00. An idle write of any non-zero value to status leaves it unchanged.
- R11: The control register reads back bit 0 of the last accepted command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_sel | input | 2 | Register select for the write |
| cfg_wr_data | input | 32 | Configuration write data |
| cfg_rd_sel | input | 2 | Register select for the read |
| cfg_rd_data | output | 32 | Registered read data |
| lb_req | output | 1 | Local bus request, held until acknowledge |
| lb_we | output | 1 | Local bus direction, 1 = store |
| lb_addr | output | 32 | Local bus address |
| lb_wdata | output | 32 | Local bus store data |
| lb_ack | input | 1 | Local bus acknowledge |
| lb_err | input | 1 | Error flag, valid with acknowledge |
| lb_rdata | input | 32 | Local bus load data, valid with acknowledge |

## Verification
A control write sampled at edge k raises `lb_req` after edge k, so the bench checks the local bus outputs at the falling edge that follows. An acknowledge sampled at edge j drops `lb_req` and updates status and data after edge j. A register read sampled at edge j shows on `cfg_rd_data` after edge j. The bench therefore pushes each expected read value when it presents the select, and the monitor compares it at the next falling edge. A watchdog abort falls exactly TIMEOUT edges after the launch edge; the bench counts falling edges to see the request still high one cycle before that edge and low right after it.

// File: rtl/lbb_pkg.sv
package lbb_pkg;
  typedef enum logic [1:0] {
    SEL_ADDR = 2'd0,
    SEL_DATA = 2'd1,
    SEL_CTRL = 2'd2,
    SEL_STAT = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    RES_PEND = 2'b00,
    RES_DONE = 2'b01,
    RES_FAIL = 2'b10
  } result_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } txn_state_e;
endpackage

// File: rtl/lbb_watchdog.sv
module lbb_watchdog #(
  parameter int LIMIT = 1024
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic expire
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  assign expire = run && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt_q <= '0;
    end else if (!expire) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R8
  wdog_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST);

  // R8
  wdog_restart_chk: assert property (@(posedge clk) disable iff (rst)
    !run |=> cnt_q == '0);
endmodule

// File: rtl/lbb_cfg_regs.sv
module lbb_cfg_regs
  import lbb_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [DW-1:0] wr_data,
  input  logic [1:0]    rd_sel,
  output logic [DW-1:0] rd_data,
  input  logic          busy,
  input  logic          fin,
  input  result_e       fin_code,
  input  logic          cap_en,
  input  logic [DW-1:0] cap_data,
  output logic [AW-1:0] addr_q,
  output logic [DW-1:0] data_q,
  output logic          launch,
  output logic          launch_we,
  output result_e       result_q
);
  localparam int PADW = DW - AW;

  reg_sel_e wsel;
  reg_sel_e rsel;
  logic     ctrl_we_q;
  logic     idle_wr;
  logic     stat_clear;

  assign wsel       = reg_sel_e'(wr_sel);
  assign rsel       = reg_sel_e'(rd_sel);
  assign idle_wr    = wr_en && !busy;
  assign launch     = idle_wr && (wsel == SEL_CTRL);
  assign launch_we  = wr_data[0];
  assign stat_clear = idle_wr && (wsel == SEL_STAT) && (wr_data == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
    end else if (idle_wr && wsel == SEL_ADDR) begin
      addr_q <= wr_data[AW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
    end else if (cap_en) begin
      data_q <= cap_data;
    end else if (idle_wr && wsel == SEL_DATA) begin
      data_q <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_we_q <= 1'b0;
    end else if (launch) begin
      ctrl_we_q <= launch_we;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result_q <= RES_PEND;
    end else if (fin) begin
      result_q <= fin_code;
    end else if (launch || stat_clear) begin
      result_q <= RES_PEND;
    end
  end

  generate
    if (PADW > 0) begin : g_pad
      always_ff @(posedge clk) begin
        if (rst) begin
          rd_data <= '0;
        end else begin
          unique case (rsel)
            SEL_ADDR: rd_data <= {{PADW{1'b0}}, addr_q};
            SEL_DATA: rd_data <= data_q;
            SEL_CTRL: rd_data <= {{(DW-1){1'b0}}, ctrl_we_q};
            default:  rd_data <= {{(DW-2){1'b0}}, result_q};
          endcase
        end
      end
    end else begin : g_nopad
      always_ff @(posedge clk) begin
        if (rst) begin
          rd_data <= '0;
        end else begin
          unique case (rsel)
            SEL_ADDR: rd_data <= addr_q;
            SEL_DATA: rd_data <= data_q;
            SEL_CTRL: rd_data <= {{(DW-1){1'b0}}, ctrl_we_q};
            default:  rd_data <= {{(DW-2){1'b0}}, result_q};
          endcase
        end
      end
    end
  endgenerate

  // R9
  busy_addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(addr_q));

  // R9
  busy_ctrl_hold_chk: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(ctrl_we_q));

  // R6
  pend_in_flight_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> result_q == RES_PEND);
endmodule

// File: rtl/lbb_txn_fsm.sv
module lbb_txn_fsm
  import lbb_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          launch,
  input  logic          launch_we,
  input  logic          lb_ack,
  input  logic          lb_err,
  input  logic [DW-1:0] lb_rdata,
  input  logic          expire,
  output logic          lb_req,
  output logic          lb_we,
  output logic          busy,
  output logic          fin,
  output result_e       fin_code,
  output logic          cap_en,
  output logic [DW-1:0] cap_data
);
  txn_state_e state_q;
  logic       acked;

  assign busy     = (state_q == ST_WAIT);
  assign acked    = busy && lb_ack;
  assign fin      = acked || expire;
  assign fin_code = (acked && !lb_err) ? RES_DONE : RES_FAIL;
  assign cap_en   = acked && !lb_err && !lb_we;
  assign cap_data = lb_rdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      lb_req  <= 1'b0;
      lb_we   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (launch) begin
            state_q <= ST_WAIT;
            lb_req  <= 1'b1;
            lb_we   <= launch_we;
          end
        end
        default: begin
          if (fin) begin
            state_q <= ST_IDLE;
            lb_req  <= 1'b0;
          end
        end
      endcase
    end
  end

  // R5
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    lb_req && !lb_ack && !expire |=> lb_req);

  // R5
  req_drop_chk: assert property (@(posedge clk) disable iff (rst)
    lb_req && lb_ack |=> !lb_req);

  // R3
  req_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(lb_req) |-> $past(launch));

  // R9
  we_stable_chk: assert property (@(posedge clk) disable iff (rst)
    lb_req && $past(lb_req) |-> $stable(lb_we));
endmodule

// File: rtl/lbus_cfg_bridge.sv
module lbus_cfg_bridge
  import lbb_pkg::*;
#(
  parameter int DW      = 32,
  parameter int AW      = 32,
  parameter int TIMEOUT = 1024
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_wr_en,
  input  logic [1:0]    cfg_wr_sel,
  input  logic [DW-1:0] cfg_wr_data,
  input  logic [1:0]    cfg_rd_sel,
  output logic [DW-1:0] cfg_rd_data,
  output logic          lb_req,
  output logic          lb_we,
  output logic [AW-1:0] lb_addr,
  output logic [DW-1:0] lb_wdata,
  input  logic          lb_ack,
  input  logic          lb_err,
  input  logic [DW-1:0] lb_rdata
);
  logic          busy;
  logic          fin;
  result_e       fin_code;
  result_e       result_q;
  logic          cap_en;
  logic [DW-1:0] cap_data;
  logic          launch;
  logic          launch_we;
  logic          expire;

  lbb_cfg_regs #(.DW(DW), .AW(AW)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (cfg_wr_en),
    .wr_sel    (cfg_wr_sel),
    .wr_data   (cfg_wr_data),
    .rd_sel    (cfg_rd_sel),
    .rd_data   (cfg_rd_data),
    .busy      (busy),
    .fin       (fin),
    .fin_code  (fin_code),
    .cap_en    (cap_en),
    .cap_data  (cap_data),
    .addr_q    (lb_addr),
    .data_q    (lb_wdata),
    .launch    (launch),
    .launch_we (launch_we),
    .result_q  (result_q)
  );

  lbb_txn_fsm #(.DW(DW)) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .launch    (launch),
    .launch_we (launch_we),
    .lb_ack    (lb_ack),
    .lb_err    (lb_err),
    .lb_rdata  (lb_rdata),
    .expire    (expire),
    .lb_req    (lb_req),
    .lb_we     (lb_we),
    .busy      (busy),
    .fin       (fin),
    .fin_code  (fin_code),
    .cap_en    (cap_en),
    .cap_data  (cap_data)
  );

  lbb_watchdog #(.LIMIT(TIMEOUT)) u_wdog (
    .clk    (clk),
    .rst    (rst),
    .run    (busy),
    .expire (expire)
  );

  // R3
  addr_stable_chk: assert property (@(posedge clk) disable iff (rst)
    lb_req && $past(lb_req) |-> $stable(lb_addr) && $stable(lb_wdata));

  // R8
  abort_fail_chk: assert property (@(posedge clk) disable iff (rst)
    lb_req && expire && !lb_ack |=> !lb_req && result_q == RES_FAIL);

  // R6
  result_legal_chk: assert property (@(posedge clk) disable iff (rst)
    result_q != 2'b11);
endmodule

// File: tb/test_lbus_cfg_bridge.sv
module test_lbus_cfg_bridge;
  localparam int TMO = 32;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_wr_en = 1'b0;
  logic [1:0]  cfg_wr_sel = '0;
  logic [31:0] cfg_wr_data = '0;
  logic [1:0]  cfg_rd_sel = '0;
  logic [31:0] cfg_rd_data;
  logic        lb_req, lb_we;
  logic [31:0] lb_addr, lb_wdata;
  logic        lb_ack = 1'b0;
  logic        lb_err = 1'b0;
  logic [31:0] lb_rdata = '0;

  int checks = 0;
  int errors = 0;
  bit done_flag = 1'b0;

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sb_q[$];

  always #10 clk = ~clk;

  lbus_cfg_bridge #(.DW(32), .AW(32), .TIMEOUT(TMO)) i_lbus_cfg_bridge (
    .clk(clk), .rst(rst),
    .cfg_wr_en(cfg_wr_en), .cfg_wr_sel(cfg_wr_sel), .cfg_wr_data(cfg_wr_data),
    .cfg_rd_sel(cfg_rd_sel), .cfg_rd_data(cfg_rd_data),
    .lb_req(lb_req), .lb_we(lb_we), .lb_addr(lb_addr), .lb_wdata(lb_wdata),
    .lb_ack(lb_ack), .lb_err(lb_err), .lb_rdata(lb_rdata)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cfg_wr(input logic [1:0] sel, input logic [31:0] val);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_wr_sel = sel; cfg_wr_data = val;
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  task automatic rd_expect(input logic [1:0] sel, input logic [31:0] exp, input string tag);
    item_t it;
    @(negedge clk);
    cfg_rd_sel = sel;
    it.exp = exp; it.tag = tag;
    sb_q.push_back(it);
  endtask

  task automatic ack(input logic err, input logic [31:0] rdat);
    @(negedge clk);
    lb_ack = 1'b1; lb_err = err; lb_rdata = rdat;
    @(negedge clk);
    lb_ack = 1'b0; lb_err = 1'b0; lb_rdata = '0;
  endtask

  // Monitor: items pushed before a rising edge are due at the following falling edge
  initial begin
    forever begin
      int n;
      @(posedge clk);
      n = sb_q.size();
      @(negedge clk);
      for (int i = 0; i < n; i++) begin
        item_t it;
        it = sb_q.pop_front();
        chk(it.tag, cfg_rd_data, it.exp);
      end
    end
  end

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 lb_req", {31'd0, lb_req}, 32'd0);
    rd_expect(2'd0, 32'd0, "R1 addr");
    rd_expect(2'd1, 32'd0, "R1 data");
    rd_expect(2'd2, 32'd0, "R1 ctrl");
    rd_expect(2'd3, 32'd0, "R1 status");

    // R2 readback
    cfg_wr(2'd0, 32'h1000_0040);
    cfg_wr(2'd1, 32'hDEAD_BEEF);
    rd_expect(2'd0, 32'h1000_0040, "R2 addr");
    rd_expect(2'd1, 32'hDEAD_BEEF, "R2 data");

    // R3 store launch
    cfg_wr(2'd2, 32'd1);
    chk("R3 lb_req", {31'd0, lb_req}, 32'd1);
    chk("R3 lb_we", {31'd0, lb_we}, 32'd1);
    chk("R3 lb_addr", lb_addr, 32'h1000_0040);
    chk("R3 lb_wdata", lb_wdata, 32'hDEAD_BEEF);
    // R9 writes ignored while busy
    cfg_wr(2'd0, 32'h0000_0005);
    cfg_wr(2'd1, 32'h0000_0006);
    cfg_wr(2'd2, 32'd0);
    chk("R9 lb_we held", {31'd0, lb_we}, 32'd1);
    rd_expect(2'd0, 32'h1000_0040, "R9 addr kept");
    rd_expect(2'd1, 32'hDEAD_BEEF, "R9 data kept");
    rd_expect(2'd3, 32'd0, "R6 pending");
    @(negedge clk);
    chk("R5 lb_req held", {31'd0, lb_req}, 32'd1);
    ack(1'b0, 32'h0);
    chk("R5 lb_req dropped", {31'd0, lb_req}, 32'd0);
    rd_expect(2'd3, 32'd1, "R6 done");
    rd_expect(2'd2, 32'd1, "R11 ctrl store");

    // R10 status clearing
    cfg_wr(2'd3, 32'd3);
    rd_expect(2'd3, 32'd1, "R10 nonzero ignored");
    cfg_wr(2'd3, 32'd0);
    rd_expect(2'd3, 32'd0, "R10 cleared");

    // R4 load
    cfg_wr(2'd0, 32'h0000_2000);
    cfg_wr(2'd2, 32'd0);
    chk("R4 lb_we", {31'd0, lb_we}, 32'd0);
    chk("R4 lb_addr", lb_addr, 32'h0000_2000);
    ack(1'b0, 32'hCAFE_F00D);
    rd_expect(2'd1, 32'hCAFE_F00D, "R4 data captured");
    rd_expect(2'd3, 32'd1, "R4 done");
    rd_expect(2'd2, 32'd0, "R11 ctrl load");

    // R7 error on load; R6 launch clears old result
    cfg_wr(2'd1, 32'h1111_2222);
    cfg_wr(2'd2, 32'd0);
    rd_expect(2'd3, 32'd0, "R6 launch clears");
    ack(1'b1, 32'h0000_9999);
    rd_expect(2'd3, 32'd2, "R7 error code");
    rd_expect(2'd1, 32'h1111_2222, "R7 data kept");

    // R8 watchdog abort
    cfg_wr(2'd2, 32'd1);
    repeat (TMO - 1) @(negedge clk);
    chk("R8 lb_req before limit", {31'd0, lb_req}, 32'd1);
    @(negedge clk);
    chk("R8 lb_req after limit", {31'd0, lb_req}, 32'd0);
    rd_expect(2'd3, 32'd2, "R8 error code");

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule